// File: doc/BRIEF.md
# Modem Line Status Tracker

This block follows the four incoming modem lines of a serial port: carrier detect, ring indicator, data set ready and clear to send. It builds the byte that software reads as modem status. Each raw line passes through a flop synchroniser. The synchronised levels are captured into the stored status only when the sample strobe is high. When a capture changes a level, a change bit is set in the low nibble. The change bits stay set until they are read. A capture that moves any level also sends a one-cycle event to the interrupt logic.

A read strobe marks a software read of the status byte. `status_o` always shows the value that such a read returns. In normal mode the change bits clear at the clock edge that ends the read. When the loop control bit is set, the byte shows the port's own modem control outputs, moved onto the level bit positions, in place of the real lines. The stored change bits are kept in this mode. Every port of the block is a plain control or status pin. No interface carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `modem_status`

## Requirements
- R1: After reset, `status_o` is 0xB0 (carrier, data set ready and clear to send active; ring and all change bits clear) and `change_evt_o` is 0.
- R2: In normal mode `status_o[7:4]` holds the captured levels: bit 7 carrier, bit 6 ring, bit 5 data set ready, bit 4 clear to send.
- R3: A capture sets bit 3 when carrier differs from its stored level, bit 1 when data set ready differs, and bit 0 when clear to send differs.
- R4: Bit 2 is set by a capture only when the ring level falls from 1 to 0. A rise of ring leaves bit 2 unchanged.
- R5: Change bits are sticky. A later capture only adds bits, so a second change before a read does not clear earlier bits.
- R6: A read in normal mode returns the current byte and clears bits 3:0 at that edge. Levels are kept. If a capture happens in the same cycle as the read, that capture's new change bits survive the clear.
- R7: With `ctl_i[4]` (loop) set, `status_o` is {ctl_i[3], ctl_i[2], ctl_i[0], ctl_i[1], 4'b0000}. Here ctl_i[3:2] are the two general outputs, ctl_i[1] is request to send and ctl_i[0] is data terminal ready. With loop clear, the stored byte is shown.
- R8: A read taken while loop is set does not clear the stored change bits.
- R9: `change_evt_o` pulses for exactly one cycle, after the edge of a capture that changed at least one level. It stays 0 otherwise.
- R10: Line changes with no sample strobe leave `status_o` unchanged.
- R11: A line change applied just after a rising edge is captured only by a strobe at the SYNC_STAGES+1-th rising edge or later. A strobe at an earlier edge still captures the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_dcd_i | input | 1 | Raw carrier detect line |
| line_ri_i | input | 1 | Raw ring indicator line |
| line_dsr_i | input | 1 | Raw data set ready line |
| line_cts_i | input | 1 | Raw clear to send line |
| sample_i | input | 1 | Capture the synchronised lines at this edge |
| rd_i | input | 1 | Software read of the status byte at this edge |
| ctl_i | input | 5 | Modem control: [4] loop, [3:2] general outputs, [1] request to send, [0] data terminal ready |
| status_o | output | 8 | Status byte as a read would return it |
| change_evt_o | output | 1 | One-cycle pulse after a level-changing capture |

## Verification
A wrong stored level shows up as a wrong upper nibble at the first edge after the capture. Its effect lasts: the next capture with a different line value sets a wrong change bit, or misses a right one. A wrong change register shows as a wrong low nibble right after the capture, or as bits that survive a read. The bench checks every pair of old and new line values. It reads after each capture to confirm that the clear happened and that the levels were kept. It also sweeps all control values in loop mode.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;
  localparam int NUM_LINES = 4;
  localparam int STAT_W    = 8;
  localparam int CTL_W     = 5;

  // control bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_GP1  = 2;
  localparam int CTL_GP2  = 3;
  localparam int CTL_LOOP = 4;

  // change nibble bit positions
  localparam int CHG_CTS  = 0;
  localparam int CHG_DSR  = 1;
  localparam int CHG_RING = 2;
  localparam int CHG_DCD  = 3;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } lines_t;

  localparam lines_t LINES_RESET = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
endpackage

// File: rtl/ms_sync.sv
module ms_sync #(
  parameter int            WIDTH  = 4,
  parameter int            STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ms_track.sv
module ms_track
  import modem_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lines_t     sync_i,
  input  logic       sample_i,
  input  logic       clr_i,
  output lines_t     lvl_o,
  output logic [3:0] chg_o,
  output logic       evt_o
);
  lines_t     lvl_q;
  logic [3:0] chg_q;
  logic       evt_q;
  logic [3:0] diff;
  logic [3:0] fresh;

  always_comb begin
    diff            = sync_i ^ lvl_q;
    fresh           = '0;
    fresh[CHG_DCD]  = diff[3];
    fresh[CHG_RING] = lvl_q.ri & ~sync_i.ri;
    fresh[CHG_DSR]  = diff[1];
    fresh[CHG_CTS]  = diff[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= LINES_RESET;
      chg_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= sample_i && (diff != '0);
      if (sample_i) lvl_q <= sync_i;
      chg_q <= (clr_i ? 4'b0000 : chg_q) | (sample_i ? fresh : 4'b0000);
    end
  end

  assign lvl_o = lvl_q;
  assign chg_o = chg_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/ms_view.sv
module ms_view
  import modem_status_pkg::*;
(
  input  logic [CTL_W-1:0]  ctl_i,
  input  lines_t            lvl_i,
  input  logic [3:0]        chg_i,
  output logic [STAT_W-1:0] stat_o
);
  always_comb begin
    if (ctl_i[CTL_LOOP])
      stat_o = {ctl_i[CTL_GP2], ctl_i[CTL_GP1], ctl_i[CTL_DTR], ctl_i[CTL_RTS], 4'b0000};
    else
      stat_o = {lvl_i, chg_i};
  end
endmodule

// File: rtl/modem_status.sv
module modem_status
  import modem_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_dcd_i,
  input  logic              line_ri_i,
  input  logic              line_dsr_i,
  input  logic              line_cts_i,
  input  logic              sample_i,
  input  logic              rd_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [STAT_W-1:0] status_o,
  output logic              change_evt_o
);
  lines_t     raw;
  lines_t     synced;
  lines_t     lvl;
  logic [3:0] chg;
  logic       clr;

  assign raw = '{dcd: line_dcd_i, ri: line_ri_i, dsr: line_dsr_i, cts: line_cts_i};
  assign clr = rd_i & ~ctl_i[CTL_LOOP];

  ms_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINES_RESET)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  ms_track u_track (
    .clk(clk), .rst_n(rst_n), .sync_i(synced), .sample_i(sample_i),
    .clr_i(clr), .lvl_o(lvl), .chg_o(chg), .evt_o(change_evt_o)
  );

  ms_view u_view (
    .ctl_i(ctl_i), .lvl_i(lvl), .chg_i(chg), .stat_o(status_o)
  );
endmodule

// File: rtl/modem_status_chk.sv
module modem_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_i,
  input logic       rd_i,
  input logic [4:0] ctl_i,
  input logic [7:0] status_o,
  input logic       change_evt_o
);
  AST_LOOP_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i[4] |-> status_o[3:0] == 4'h0); // R7

  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sample_i) && !$past(rd_i) && !$past(ctl_i[4]) && !ctl_i[4]) |-> $stable(status_o)); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !ctl_i[4] && !sample_i) |=> (ctl_i[4] || status_o[3:0] == 4'h0)); // R6

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i[4] && !rd_i) |=> (ctl_i[4] || ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])))); // R5

  AST_EVT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    change_evt_o |-> $past(sample_i)); // R9

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    change_evt_o |=> !change_evt_o); // R9

  AST_NEW_CHG_HAS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i[4] && !$past(ctl_i[4]) && ((status_o[3:0] & ~$past(status_o[3:0])) != 4'h0)) |-> change_evt_o); // R3
endmodule

bind modem_status modem_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .rd_i(rd_i), .ctl_i(ctl_i),
  .status_o(status_o), .change_evt_o(change_evt_o)
);

// File: tb/tb_modem_status.sv
module tb_modem_status;
  localparam int STG = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_dcd = 1'b1, l_ri = 1'b0, l_dsr = 1'b1, l_cts = 1'b1;
  logic       sample = 1'b0;
  logic       rd = 1'b0;
  logic [4:0] ctl = 5'd0;
  logic [7:0] status;
  logic       evt;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modem_status #(.SYNC_STAGES(STG)) dut (
    .clk(clk), .rst_n(rst_n), .line_dcd_i(l_dcd), .line_ri_i(l_ri),
    .line_dsr_i(l_dsr), .line_cts_i(l_cts), .sample_i(sample), .rd_i(rd),
    .ctl_i(ctl), .status_o(status), .change_evt_o(evt)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic set_lines(input logic [3:0] v);
    {l_dcd, l_ri, l_dsr, l_cts} = v;
  endtask

  task automatic apply_lines(input logic [3:0] v);
    set_lines(v);
    repeat (STG) @(negedge clk);
  endtask

  task automatic strobe();
    sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
  endtask

  task automatic rd_clear();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [3:0] exp_chg(input logic [3:0] p, input logic [3:0] n);
    logic [3:0] x;
    x = p ^ n;
    return {x[3], p[2] & ~n[2], x[1], x[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", status, 8'hB0);
    check("R1 reset event", {7'd0, evt}, 8'h00);

    // R2 R3 R4 R9 R6: every old/new line pair
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        apply_lines(4'(p));
        strobe();
        rd_clear();
        apply_lines(4'(n));
        strobe();
        check("R2/R3/R4 capture", status, {4'(n), exp_chg(4'(p), 4'(n))});
        check("R9 event pulse", {7'd0, evt}, {7'd0, (p != n)});
        @(negedge clk);
        check("R9 event one cycle", {7'd0, evt}, 8'h00);
        rd_clear();
        check("R6 read clears changes", status, {4'(n), 4'h0});
      end
    end

    // R10: no strobe, no effect
    apply_lines(4'b1011);
    strobe();
    rd_clear();
    set_lines(4'b0000);
    repeat (5) @(negedge clk);
    check("R10 no strobe", status, 8'hB0);

    // R11: sync latency
    apply_lines(4'b1011);
    strobe();
    rd_clear();
    set_lines(4'b0100);
    @(negedge clk);
    strobe();
    check("R11 early strobe sees old", status, 8'hB0);
    strobe();
    check("R11 late strobe sees new", status, 8'h4B);

    // R5: sticky changes
    rd_clear();
    apply_lines(4'b0000);
    strobe();
    apply_lines(4'b0001);
    strobe();
    check("R5 sticky", status, 8'h15);

    // R6: read and capture in the same cycle
    apply_lines(4'b1001);
    sample = 1'b1;
    rd = 1'b1;
    #1;
    check("R6 read value", status, 8'h15);
    @(negedge clk);
    sample = 1'b0;
    rd = 1'b0;
    check("R6 same-cycle capture kept", status, 8'h98);
    rd_clear();

    // R7: loop view sweep
    for (int c = 0; c < 16; c++) begin
      ctl = {1'b1, 4'(c)};
      #1;
      check("R7 loop view", status, {c[3], c[2], c[0], c[1], 4'h0});
      @(negedge clk);
    end
    ctl = 5'b01111;
    #1;
    check("R7 loop off", status, 8'h90);

    // R8: loop read keeps changes
    apply_lines(4'b1000);
    strobe();
    check("R8 setup", status, 8'h81);
    ctl = 5'b10000;
    rd_clear();
    ctl = 5'b00000;
    #1;
    check("R8 loop read keeps", status, 8'h81);
    @(negedge clk);
    rd_clear();
    check("R6 normal read clears", status, 8'h80);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule